// File: doc/BRIEF.md
# Pipelined Carry-Save Bit-Level Multiplier

This block multiplies two unsigned operands of `N` bits each and gives a `2N`-bit product. It accepts a new operand pair on every clock. The core is a square grid of `N*N` one-bit cells. Each cell ANDs one bit of each operand and adds that partial product to a sum bit and a carry bit from the row above. Every cell input and output is registered. Operand bits and partial results therefore travel only to adjacent cells, so the clock period is bounded by the delay of one cell plus one register.

Operand A moves down the columns of the grid and operand B moves along the rows. The two are skewed in time: A presents its most significant bit first and B presents its least significant bit first, so that every bit of A meets every bit of B. A sum bit takes two register hops to move to the cell of the same weight in the next row. A carry bit takes one hop and moves to the next more significant column. Because of this, no carry ever ripples inside a clock.

The block has a parallel interface on both sides. Skew registers at the input and deskew registers at the output hide the bit staggering. The residual carries from the last row are resolved by an adder split into `SEG`-bit slices, with one slice per pipeline stage. A valid flag travels beside the data with the same latency.

Top module: `csm_mult`

## Requirements
- R1: While `rst_n` is low, and for the first LAT clock edges after it rises, `out_valid` is 0 and `out_prod` is 0.
- R2: `out_prod` equals the unsigned product `op_a * op_b` of the pair sampled LAT rising edges earlier. The edge that samples the pair counts as the first, so the result is on the outputs right after edge number LAT. LAT = 2*N + N/SEG, which is 18 for N=8 and SEG=4.
- R3: `out_valid` equals the value of `in_valid` sampled at the same edge as the pair whose product is on `out_prod`.
- R4: A pair is accepted on every clock with no gap. Each product depends only on its own pair, whatever pairs come before or after it.
- R5: Operand extremes give exact results: an operand of 0 gives a product of 0, and all-ones times all-ones gives (2^N-1)^2 (0xFE01 for N=8). No product exceeds (2^N-1)^2, and the final adder never carries out of bit 2N-1.
- R6: `in_valid` does not gate the data path. A pair sampled while `in_valid` is 0 still yields its exact product on `out_prod`, with `out_valid` at 0.
- R7: `SEG` must divide `N`. Elaboration is rejected otherwise, and each additional slice of the final adder adds one clock to LAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all pipeline registers |
| in_valid | input | 1 | Tags the operand pair sampled on this edge |
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| out_valid | output | 1 | Tag of the pair whose product is on `out_prod` |
| out_prod | output | 2N | Unsigned product |

## Verification
Every product and every valid tag is due exactly LAT = 18 rising edges after its pair is sampled, with the sampling edge counted as the first. The bench keeps a ring of the pairs it has driven, indexed by cycle. On each falling edge it compares the outputs with the entry driven LAT cycles earlier, so one misplaced register anywhere shows up as a mismatch. Cycles before the first pair can arrive are expected to show zeros. The full 65536-pair sweep is streamed back to back, and is followed by a stretch where the valid tag toggles while the data keeps changing.

// File: rtl/csm_pkg.sv
package csm_pkg;

   // Clock edges from sampling a pair to its product on the outputs.
   function automatic int csm_latency(input int n, input int seg);
      return 2 * n + n / seg;
   endfunction

   // Register depth that aligns an array output bit to the common cycle.
   function automatic int csm_low_depth(input int n, input int seg, input int k);
      return (n - 1 - k) + n / seg;
   endfunction

endpackage

// File: rtl/csm_delay.sv
module csm_delay #(
   parameter int W = 1,
   parameter int D = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (W < 1) begin : g_bad_w
      $error("csm_delay: W must be at least 1");
   end
   if (D < 0) begin : g_bad_d
      $error("csm_delay: D must not be negative");
   end

   if (D == 0) begin : g_wire
      assign dout = din;
   end else begin : g_regs
      logic [W-1:0] stg [D];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < D; k++) stg[k] <= '0;
         end else begin
            stg[0] <= din;
            for (int k = 1; k < D; k++) stg[k] <= stg[k-1];
         end
      end
      assign dout = stg[D-1];
   end

endmodule

// File: rtl/csm_cell.sv
module csm_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic a_in,
   input  logic b_in,
   input  logic s_in,
   input  logic c_in,
   output logic a_out,
   output logic b_out,
   output logic s_out,
   output logic c_out
);

   logic s_lat;
   logic pp;
   logic sum_n;
   logic cy_n;

   assign pp    = a_in & b_in;
   assign sum_n = s_lat ^ c_in ^ pp;
   assign cy_n  = (s_lat & c_in) | (s_lat & pp) | (c_in & pp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_out <= 1'b0;
         b_out <= 1'b0;
         s_lat <= 1'b0;
         s_out <= 1'b0;
         c_out <= 1'b0;
      end else begin
         a_out <= a_in;
         b_out <= b_in;
         s_lat <= s_in;
         s_out <= sum_n;
         c_out <= cy_n;
      end
   end

   // R2: a carry can only come from accumulated state, never from the partial product alone
   p_carry_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      c_out |-> $past(s_lat | c_in));

endmodule

// File: rtl/csm_array.sv
module csm_array #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] a_edge,
   input  logic [N-1:0] b_edge,
   output logic [N-2:0] lo_bits,
   output logic [N-1:0] hi_sum,
   output logic [N-1:0] hi_carry
);

   logic a_q [N][N];
   logic b_q [N][N];
   logic s_q [N][N];
   logic c_q [N][N];

   for (genvar i = 0; i < N; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         logic a_src;
         logic b_src;
         logic s_src;
         logic c_src;

         if (i == 0) begin : g_a_top
            assign a_src = a_edge[j];
         end else begin : g_a_mid
            assign a_src = a_q[i-1][j];
         end

         if (j == N - 1) begin : g_b_edge
            assign b_src = b_edge[i];
         end else begin : g_b_mid
            assign b_src = b_q[i][j+1];
         end

         if (i == 0 || j == N - 1) begin : g_s_zero
            assign s_src = 1'b0;
         end else begin : g_s_diag
            assign s_src = s_q[i-1][j+1];
         end

         if (i == 0) begin : g_c_zero
            assign c_src = 1'b0;
         end else begin : g_c_up
            assign c_src = c_q[i-1][j];
         end

         csm_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .a_in  (a_src),
            .b_in  (b_src),
            .s_in  (s_src),
            .c_in  (c_src),
            .a_out (a_q[i][j]),
            .b_out (b_q[i][j]),
            .s_out (s_q[i][j]),
            .c_out (c_q[i][j])
         );
      end
   end

   for (genvar k = 0; k < N - 1; k++) begin : g_lo
      assign lo_bits[k] = s_q[k][0];
   end

   for (genvar j = 0; j < N; j++) begin : g_hi
      assign hi_sum[j]   = s_q[N-1][j];
      assign hi_carry[j] = c_q[N-1][j];
   end

endmodule

// File: rtl/csm_segadd.sv
module csm_segadd #(
   parameter int N   = 8,
   parameter int SEG = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] x,
   input  logic [N-1:0] y,
   output logic [N-1:0] sum
);

   localparam int NSEG = N / SEG;

   if (N % SEG != 0) begin : g_bad_seg
      $error("csm_segadd: SEG must divide N");
   end

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      logic [SEG-1:0] xs;
      logic [SEG-1:0] ys;
      logic           cin;
      logic           co_r;
      logic [SEG-1:0] r_r;

      csm_delay #(.W(SEG), .D(s)) u_dx (
         .clk(clk), .rst_n(rst_n), .din(x[s*SEG +: SEG]), .dout(xs));
      csm_delay #(.W(SEG), .D(s)) u_dy (
         .clk(clk), .rst_n(rst_n), .din(y[s*SEG +: SEG]), .dout(ys));

      if (s == 0) begin : g_cin0
         assign cin = 1'b0;
      end else begin : g_cinp
         assign cin = g_seg[s-1].co_r;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            co_r <= 1'b0;
            r_r  <= '0;
         end else begin
            {co_r, r_r} <= {1'b0, xs} + {1'b0, ys} + {{SEG{1'b0}}, cin};
         end
      end

      csm_delay #(.W(SEG), .D(NSEG - 1 - s)) u_dr (
         .clk(clk), .rst_n(rst_n), .din(r_r), .dout(sum[s*SEG +: SEG]));

      if (s == NSEG - 1) begin : g_top_chk
         // R5: a true product never carries out of its top slice
         p_top_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !co_r);
      end
   end

endmodule

// File: rtl/csm_mult.sv
module csm_mult #(
   parameter int N   = 8,
   parameter int SEG = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [N-1:0]   op_a,
   input  logic [N-1:0]   op_b,
   output logic           out_valid,
   output logic [2*N-1:0] out_prod
);

   localparam int NSEG = N / SEG;
   localparam int LAT  = csm_pkg::csm_latency(N, SEG);
   localparam int CW   = $clog2(LAT + 1);
   localparam logic [2*N-1:0] MAXP = {{(N-1){1'b1}}, 1'b0, {(N-1){1'b0}}, 1'b1};

   // R7: elaboration-time parameter checks
   if (N < 2) begin : g_bad_n
      $error("csm_mult: N must be at least 2");
   end
   if (SEG < 1 || SEG > N || (N % SEG) != 0) begin : g_bad_seg
      $error("csm_mult: SEG must divide N");
   end

   // Input skew: A most significant bit first, B least significant bit first.
   logic [N-1:0] a_edge;
   logic [N-1:0] b_edge;

   for (genvar j = 0; j < N; j++) begin : g_skew_a
      csm_delay #(.W(1), .D(N - j)) u_sa (
         .clk(clk), .rst_n(rst_n), .din(op_a[j]), .dout(a_edge[j]));
   end
   for (genvar i = 0; i < N; i++) begin : g_skew_b
      csm_delay #(.W(1), .D(i + 1)) u_sb (
         .clk(clk), .rst_n(rst_n), .din(op_b[i]), .dout(b_edge[i]));
   end

   logic [N-2:0] lo_bits;
   logic [N-1:0] hi_sum;
   logic [N-1:0] hi_carry;

   csm_array #(.N(N)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_edge   (a_edge),
      .b_edge   (b_edge),
      .lo_bits  (lo_bits),
      .hi_sum   (hi_sum),
      .hi_carry (hi_carry)
   );

   // Output deskew: low bits are final early and wait for the adder.
   logic [N-1:0] lo_full;
   logic [N-1:0] lo_al;
   assign lo_full = {hi_sum[0], lo_bits};

   for (genvar k = 0; k < N; k++) begin : g_deskew_lo
      csm_delay #(.W(1), .D(csm_pkg::csm_low_depth(N, SEG, k))) u_dl (
         .clk(clk), .rst_n(rst_n), .din(lo_full[k]), .dout(lo_al[k]));
   end

   logic [N-1:0] hs_al;
   logic [N-1:0] hc_al;
   assign hs_al[0] = 1'b0;

   for (genvar j = 1; j < N; j++) begin : g_deskew_hs
      csm_delay #(.W(1), .D(j)) u_dh (
         .clk(clk), .rst_n(rst_n), .din(hi_sum[j]), .dout(hs_al[j]));
   end
   for (genvar j = 0; j < N; j++) begin : g_deskew_hc
      csm_delay #(.W(1), .D(j)) u_dc (
         .clk(clk), .rst_n(rst_n), .din(hi_carry[j]), .dout(hc_al[j]));
   end

   logic [N-1:0] add_x;
   logic [N-1:0] hi_res;
   assign add_x = {1'b0, hs_al[N-1:1]};

   csm_segadd #(.N(N), .SEG(SEG)) u_final (
      .clk   (clk),
      .rst_n (rst_n),
      .x     (add_x),
      .y     (hc_al),
      .sum   (hi_res)
   );

   assign out_prod = {hi_res, lo_al};

   csm_delay #(.W(1), .D(LAT)) u_valid (
      .clk(clk), .rst_n(rst_n), .din(in_valid), .dout(out_valid));

   // Edges since reset, saturating; used by the start-up window check.
   logic [CW-1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != CW'(LAT)) since_rst <= since_rst + 1'b1;
   end

   // R1: nothing may be tagged valid before the first pair can arrive
   p_quiet_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < CW'(LAT)) |-> !out_valid);

   // R5: the product never exceeds (2^N-1)^2
   p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_prod <= MAXP);

endmodule

// File: tb/sim_csm_mult.sv
module sim_csm_mult;

   localparam int N   = 8;
   localparam int SEG = 4;
   localparam int LAT = 2 * N + N / SEG;
   localparam int NSWEEP = 65536;
   localparam int NTOG   = 64;

   logic           clk;
   logic           rst_n;
   logic           in_valid;
   logic [N-1:0]   op_a;
   logic [N-1:0]   op_b;
   logic           out_valid;
   logic [2*N-1:0] out_prod;

   csm_mult #(.N(N), .SEG(SEG)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .op_a     (op_a),
      .op_b     (op_b),
      .out_valid(out_valid),
      .out_prod (out_prod)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [N-1:0] ha [64];
   logic [N-1:0] hb [64];
   logic         hv [64];

   initial clk = 1'b0;
   always #10 clk = ~clk;

   function automatic string tag_for(int c, logic [N-1:0] a, logic [N-1:0] b, logic v);
      if (c < LAT) return "R1";
      if (a == 0 || b == 0 || a == '1 || b == '1) return "R5";
      if (!v) return "R6";
      return "R2,R4";
   endfunction

   task automatic drive(int c);
      logic [N-1:0] a;
      logic [N-1:0] b;
      logic         v;
      if (c < NSWEEP) begin
         v = 1'b1;
         a = N'(c >> N);
         b = N'(c);
      end else if (c < NSWEEP + NTOG) begin
         v = c[0];
         a = N'(c * 37 + 3);
         b = N'(c * 101 + 7);
      end else begin
         v = 1'b0;
         a = '0;
         b = '0;
      end
      in_valid = v;
      op_a     = a;
      op_b     = b;
      ha[c % 64] = a;
      hb[c % 64] = b;
      hv[c % 64] = v;
   endtask

   task automatic check(int c);
      logic [2*N-1:0] ep;
      logic           ev;
      string          t;
      if (c < LAT) begin
         ep = '0;
         ev = 1'b0;
         t  = "R1";
      end else begin
         int n = (c - LAT) % 64;
         ep = (2*N)'(ha[n]) * (2*N)'(hb[n]);
         ev = hv[n];
         t  = tag_for(c, ha[n], hb[n], hv[n]);
      end
      checks++;
      if (out_prod !== ep) begin
         errors++;
         $display("FAIL %s cycle %0d out_prod actual %h expected %h", t, c, out_prod, ep);
      end
      checks++;
      if (out_valid !== ev) begin
         errors++;
         $display("FAIL %s R3 cycle %0d out_valid actual %b expected %b",
                  (c < LAT) ? "R1" : "R3", c, out_valid, ev);
      end
   endtask

   initial begin
      for (int k = 0; k < 64; k++) begin
         ha[k] = '0;
         hb[k] = '0;
         hv[k] = 1'b0;
      end
      rst_n    = 1'b0;
      in_valid = 1'b1;
      op_a     = '1;
      op_b     = '1;
      repeat (3) @(negedge clk);
      // R1: outputs held clear during reset even with live inputs
      checks++;
      if (out_prod !== '0 || out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 in reset actual %h/%b expected 0000/0", out_prod, out_valid);
      end
      rst_n = 1'b1;
      drive(0);
      for (int c = 1; c < NSWEEP + NTOG + LAT + 4; c++) begin
         @(negedge clk);
         check(c);
         drive(c);
      end
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(64'd200000 * 64'd20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog expired actual running expected finished");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule